// File: doc/BRIEF.md
# Mode-switching dual sequence detector

This block watches a single serial bit stream, one bit per rising clock edge, and raises two Mealy flags. `hit_a` marks the arrival of the last bit of the pattern 1-0-1, and `hit_b` marks the last bit of 1-1-0 (both oldest bit first). Matches may overlap: bits from one match count towards the next.

The detector has two modes. In full mode both flags are live. A `hit_b` report moves it into a reduced mode in which `hit_b` stays at 0 while the bit history is still followed. The next `hit_a` report in reduced mode brings it back to full mode. The composite machine is held in three state bits: one mode bit and a two-bit history class. A synchronous clear discards the history and selects full mode.

Top module: `dual_seq_detector`

## Requirements
- R1: When `clr` is 1 at a rising edge, the next cycle starts in full mode with empty history. While `clr` is 1, `hit_a` and `hit_b` are both 0.
- R2: `hit_a` is 1 in the cycle where `din` is 1 and the two bits sampled just before, oldest first, were 1 then 0. The output changes combinationally with `din` in that same cycle.
- R3: In full mode, `hit_b` is 1 in the cycle where `din` is 0 and the two bits sampled just before were 1 then 1.
- R4: Overlapping matches are reported. The stream 1,0,1,0,1 gives `hit_a` on the third and fifth bits, and 1,1,1,0 gives `hit_b` on the fourth bit.
- R5: `hit_a` and `hit_b` are never 1 in the same cycle.
- R6: A `hit_b` report puts the block in reduced mode from the next cycle on. In reduced mode `hit_b` stays 0, even when 1,1,0 completes.
- R7: The bit history is kept across a mode change. For example, 1,1,0 followed by 1 reports `hit_a` on that 1.
- R8: In reduced mode, a `hit_a` report returns the block to full mode from the next cycle on. A completed 1,1,0 in reduced mode leaves the mode unchanged.
- R9: Only bits sampled after the last clear count towards a match. For example, 1,0, then a clear, then 1 gives no `hit_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high |
| din | input | 1 | Serial data bit |
| hit_a | output | 1 | Pattern 1-0-1 completed this cycle |
| hit_b | output | 1 | Pattern 1-1-0 completed this cycle (full mode only) |

## Verification
The embedded properties assume that `clr` is high from the first edge, so the state register is defined before any property is enabled, and that `din` and `clr` are stable around the sampling edge. The stimulus holds clear for the first cycles, then changes inputs only at falling edges. Random runs insert clears now and then, so matches that straddle a clear and mode changes that follow one are exercised together with long streams that cross many mode boundaries.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

   localparam int HIST_W   = 2;
   localparam int HIST_CNT = 1 << HIST_W;

   // Classes of recent bit history that matter for both patterns
   typedef enum logic [HIST_W-1:0] {
      H_NONE    = 2'd0,  // no useful prefix
      H_ONE     = 2'd1,  // last bit 1, bit before it not 1
      H_ONEONE  = 2'd2,  // last two bits 1,1
      H_ONEZERO = 2'd3   // last two bits 1,0
   } hist_e;

   function automatic hist_e hist_next(input hist_e cur, input logic bit_in);
      hist_e nxt;
      unique case (cur)
         H_NONE:    nxt = bit_in ? H_ONE    : H_NONE;
         H_ONE:     nxt = bit_in ? H_ONEONE : H_ONEZERO;
         H_ONEONE:  nxt = bit_in ? H_ONEONE : H_ONEZERO;
         H_ONEZERO: nxt = bit_in ? H_ONE    : H_NONE;
         default:   nxt = H_NONE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/dsd_history.sv
module dsd_history
   import dsd_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
) (
   input  logic  clk,
   input  logic  clr,
   input  logic  din,
   output hist_e hist
);

   generate
      if (ONEHOT) begin : g_onehot
         logic [HIST_CNT-1:0] oh_q;
         hist_e               cur;

         always_comb begin
            cur = H_NONE;
            for (int i = 0; i < HIST_CNT; i++) begin
               if (oh_q[i]) cur = hist_e'(i[HIST_W-1:0]);
            end
         end

         always_ff @(posedge clk) begin
            if (clr) oh_q <= HIST_CNT'(1);
            else     oh_q <= HIST_CNT'(1) << hist_next(cur, din);
         end

         assign hist = cur;

         AST_HIST_ONE_HOT: assert property (@(posedge clk) disable iff (clr)
            $countones(oh_q) == 1);  // R1
      end else begin : g_binary
         hist_e q;

         always_ff @(posedge clk) begin
            if (clr) q <= H_NONE;
            else     q <= hist_next(q, din);
         end

         assign hist = q;
      end
   endgenerate

   AST_CLR_EMPTIES_HIST: assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> hist == H_NONE);  // R9

endmodule

// File: rtl/dsd_mode.sv
module dsd_mode (
   input  logic clk,
   input  logic clr,
   input  logic hit_a,
   input  logic hit_b,
   output logic reduced
);

   logic red_q;

   always_ff @(posedge clk) begin
      if (clr)        red_q <= 1'b0;
      else if (hit_b) red_q <= 1'b1;
      else if (hit_a) red_q <= 1'b0;
   end

   assign reduced = red_q;

   AST_CLR_FULL_MODE: assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> !reduced);  // R1
   AST_B_ENTERS_REDUCED: assert property (@(posedge clk) disable iff (clr)
      hit_b |=> reduced);  // R6
   AST_A_LEAVES_REDUCED: assert property (@(posedge clk) disable iff (clr)
      (reduced && hit_a) |=> !reduced);  // R8
   AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (clr)
      (!hit_a && !hit_b) |=> $stable(reduced));  // R8

endmodule

// File: rtl/dsd_match.sv
module dsd_match
   import dsd_pkg::*;
(
   input  logic  clr,
   input  logic  din,
   input  hist_e hist,
   input  logic  reduced,
   output logic  hit_a,
   output logic  hit_b
);

   logic a_raw, b_raw;

   always_comb begin
      a_raw = din  && (hist == H_ONEZERO);
      b_raw = !din && (hist == H_ONEONE);
      hit_a = !clr && a_raw;
      hit_b = !clr && b_raw && !reduced;
   end

   always_comb begin
      AST_NEVER_BOTH: assert (!(hit_a && hit_b));  // R5
   end

endmodule

// File: rtl/dual_seq_detector.sv
module dual_seq_detector #(
   parameter bit HIST_ONEHOT = 1'b0
) (
   input  logic clk,
   input  logic clr,
   input  logic din,
   output logic hit_a,
   output logic hit_b
);
   import dsd_pkg::*;

   generate
      if (HIST_W != 2 || HIST_CNT != 4) begin : g_bad_cfg
         $error("history class encoding must be 2 bits wide");
      end
   endgenerate

   hist_e hist;
   logic  reduced;

   dsd_history #(.ONEHOT(HIST_ONEHOT)) u_hist (
      .clk  (clk),
      .clr  (clr),
      .din  (din),
      .hist (hist)
   );

   dsd_match u_match (
      .clr     (clr),
      .din     (din),
      .hist    (hist),
      .reduced (reduced),
      .hit_a   (hit_a),
      .hit_b   (hit_b)
   );

   dsd_mode u_mode (
      .clk     (clk),
      .clr     (clr),
      .hit_a   (hit_a),
      .hit_b   (hit_b),
      .reduced (reduced)
   );

   AST_CLR_SILENT: assert property (@(posedge clk)
      clr |-> (!hit_a && !hit_b));  // R1
   AST_A_BITS: assert property (@(posedge clk) disable iff (clr)
      hit_a |-> ($past(din, 2) && !$past(din) && din));  // R2
   AST_B_BITS: assert property (@(posedge clk) disable iff (clr)
      hit_b |-> ($past(din, 2) && $past(din) && !din));  // R3

endmodule

// File: tb/sim_dual_seq_detector.sv
module sim_dual_seq_detector;

   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic clr = 1'b1;
   logic din = 1'b0;
   logic hit_a, hit_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model: mode flag plus shift history of bits since clear
   bit       m_reduced = 1'b0;
   bit [2:0] m_hist = 3'b000;
   int       m_cnt = 0;

   always #(PERIOD/2) clk = ~clk;

   dual_seq_detector u0 (
      .clk   (clk),
      .clr   (clr),
      .din   (din),
      .hit_a (hit_a),
      .hit_b (hit_b)
   );

   function automatic bit exp_a(input bit c, input bit b);
      return !c && m_cnt >= 2 && m_hist[1:0] == 2'b10 && b;
   endfunction

   function automatic bit exp_b(input bit c, input bit b);
      return !c && !m_reduced && m_cnt >= 2 && m_hist[1:0] == 2'b11 && !b;
   endfunction

   task automatic check(input string tag, input bit act, input bit exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit c, input bit b, input string tag);
      bit ea, eb;
      @(negedge clk);
      clr = c;
      din = b;
      #(PERIOD/4);
      ea = exp_a(c, b);
      eb = exp_b(c, b);
      check(tag, hit_a, ea, "hit_a");
      check(tag, hit_b, eb, "hit_b");
      check("R5", hit_a && hit_b, 1'b0, "both_high");
      if (c) begin
         m_reduced = 1'b0; m_hist = 3'b000; m_cnt = 0;
      end else begin
         if (eb) m_reduced = 1'b1;
         else if (ea) m_reduced = 1'b0;
         m_hist = {m_hist[1:0], b};
         if (m_cnt < 3) m_cnt++;
      end
   endtask

   task automatic stream(input string bits, input string tag);
      for (int i = 0; i < bits.len(); i++) step(1'b0, bits[i] == "1", tag);
   endtask

   initial begin
      // R1: clear holds outputs low regardless of input
      step(1'b1, 1'b1, "R1");
      step(1'b1, 1'b0, "R1");
      step(1'b1, 1'b1, "R1");
      stream("101", "R2");
      step(1'b1, 1'b0, "R1");
      stream("10101", "R4");
      step(1'b1, 1'b0, "R1");
      stream("1110", "R3");
      stream("110", "R6");
      stream("1", "R7");
      stream("10", "R8");
      stream("0110110", "R8");
      stream("101", "R8");
      stream("110", "R8");
      // clear inside a half-formed pattern
      stream("10", "R9");
      step(1'b1, 1'b1, "R1");
      stream("1", "R9");
      stream("011", "R9");
      step(1'b1, 1'b1, "R1");
      stream("0", "R9");
      // long random streams with occasional clears
      for (int i = 0; i < 4000; i++) begin
         bit rc, rb;
         rc = ($urandom % 64) == 0;
         rb = ($urandom % 3) != 0;
         step(rc, rb, "R2 R3 R6 R7 R8");
      end
      for (int i = 0; i < 2000; i++) step(1'b0, $urandom % 2, "R4 R6 R8");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      process::self().srandom(32'd1234);
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule